// File: doc/BRIEF.md
# Return-to-zero serial word transmitter

This block is one transmit channel of a two-wire return-to-zero serial link. A host fills a 32-bit word by writing four bytes through an index that advances on every write and wraps modulo four. The first byte written is the label. The word's parity bit is part of the data the host writes, so the block does not compute parity. A start request shifts the word out, least significant bit first, at a bit rate set by an even divider of the system clock. Each bit drives a pulse on exactly one of two lines. The "one" line pulses for a 1 bit and the "zero" line pulses for a 0 bit. Each pulse lasts the first half of the bit period.

The shift register rotates the word instead of consuming it. After the 32nd bit the word is back in its loaded position, so a new start request sends the same word again without a reload. A start request made during the quiet gap that follows a word is held. It launches the next word exactly four bit periods after the previous word ended. A loopback mode sends the line pulses to one of several receive-channel taps instead of the external lines. Any later control access ends loopback.

Top module: `rz_word_tx`

## Requirements
- R1: While reset is applied and after it, `busy`, `done`, both external lines and every loopback tap are 0.
- R2: The bit period is n system cycles. n is `div_n` with its bit 0 forced to 0, and any result below 2 is raised to 2. The active line is high for the first n/2 cycles of each bit period and low for the remaining cycles.
- R3: During the high half of a bit period, `line_one` is high when the current bit is 1 and `line_zero` is high when it is 0. The two lines are never high together.
- R4: Byte writes (`byte_we`) are stored only while program enable is set and `busy` is 0. The nth accepted byte fills word bits [8k+7:8k], where k = (n-1) mod 4. So the first byte fills the label, bits 7:0, and the fifth write overwrites the label.
- R5: Word bit 0 is transmitted first and bit 31 last.
- R6: A control write with `ctrl_prog`=1 returns the byte index to the label and clears `done`.
- R7: From idle, a control write with `ctrl_start`=1 starts bit 0 in the cycle after the write. `busy` is then 1 for exactly 32·n cycles. When it falls, `done` is 1 and both lines are 0.
- R8: A start request made during the 4-bit-period gap after a word is held. The same word is then sent again, with no reload, starting exactly 4·n cycles after the 32nd bit period ends.
- R9: A start request made while `busy` is 1 is ignored. It neither lengthens the current word nor causes a retransmission.
- R10: A control write with both `ctrl_start` and `ctrl_loop` set turns on loopback. In loopback the line pulses go to the lowest-numbered tap whose bit is set in `ctrl_sel`, where bit k selects tap k. The external lines and all other taps stay 0.
- R11: Any control write or a `ctrl_rd` strobe that does not set loopback again turns loopback off. The pulses then return to the external lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_rd | input | 1 | Control read strobe (ends loopback) |
| ctrl_prog | input | 1 | Program-enable bit of a control write |
| ctrl_start | input | 1 | Start bit of a control write |
| ctrl_loop | input | 1 | Loopback bit of a control write |
| ctrl_sel | input | NCH | Receive tap select of a control write |
| byte_we | input | 1 | Message byte write strobe |
| byte_data | input | BYTE_W | Message byte |
| div_n | input | DIV_W | Bit-rate divider value |
| line_one | output | 1 | Return-to-zero "one" line |
| line_zero | output | 1 | Return-to-zero "zero" line |
| busy | output | 1 | Word being shifted out |
| done | output | 1 | Last word finished |
| lb_one | output | NCH | Loopback "one" pulses per receive tap |
| lb_zero | output | NCH | Loopback "zero" pulses per receive tap |

## Verification
The bench builds the block with its defaults: four loopback taps, 8-bit bytes and an 8-bit divider. Divider values from 0 to 9 keep a full word between 64 and 256 cycles. That makes it practical to check every bit pulse, both halves of each bit period, the exact length of `busy` and the exact 4-bit-period gap before a held retransmission. The four taps allow a select mask with several bits set, which shows that the lowest-numbered selected tap wins.

// File: rtl/rzt_pkg.sv
package rzt_pkg;

    localparam int unsigned DEF_NCH    = 4;
    localparam int unsigned DEF_BYTE_W = 8;
    localparam int unsigned DEF_NBYTES = 4;
    localparam int unsigned DEF_DIV_W  = 8;
    localparam int unsigned DEF_GAP    = 4;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_GAP   = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic prog;
        logic start;
        logic loop;
    } ctrl_word_t;

    // Even division ratio: bit 0 dropped, floor of 2.
    function automatic int unsigned even_ratio(input int unsigned raw);
        int unsigned e;
        e = raw & ~32'd1;
        return (e < 2) ? 2 : e;
    endfunction

endpackage

// File: rtl/rzt_bitclk.sv
module rzt_bitclk #(
    parameter int unsigned DIV_W = rzt_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_raw,
    output logic             tick,
    output logic             phase_hi
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] ratio_q;
    logic [DIV_W-1:0] ratio_new;

    assign ratio_new = DIV_W'(rzt_pkg::even_ratio(32'(div_raw)));
    assign tick      = run && (cnt_q == ratio_q - DIV_W'(1));
    assign phase_hi  = cnt_q < (ratio_q >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ratio_q <= DIV_W'(2);
        end else if (restart) begin
            cnt_q   <= '0;
            ratio_q <= ratio_new;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/rzt_shreg.sv
module rzt_shreg #(
    parameter int unsigned BYTE_W = rzt_pkg::DEF_BYTE_W,
    parameter int unsigned NBYTES = rzt_pkg::DEF_NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_clr,
    input  logic              byte_wr,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rotate,
    output logic              cur_bit
);
    localparam int unsigned WORD_W = BYTE_W * NBYTES;
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;

    assign cur_bit = word_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (idx_clr) begin
            idx_q <= '0;
        end else if (byte_wr) begin
            word_q[idx_q*BYTE_W +: BYTE_W] <= byte_in;
            idx_q <= (idx_q == IDX_W'(NBYTES-1)) ? '0 : idx_q + IDX_W'(1);
        end else if (rotate) begin
            // recirculate: bit 0 leaves, returns at the top
            word_q <= {word_q[0], word_q[WORD_W-1:1]};
        end
    end
endmodule

// File: rtl/rzt_route.sv
module rzt_route #(
    parameter int unsigned NCH = rzt_pkg::DEF_NCH
) (
    input  logic           lb_on,
    input  logic [NCH-1:0] sel,
    input  logic           one_in,
    input  logic           zero_in,
    output logic           ext_one,
    output logic           ext_zero,
    output logic [NCH-1:0] ch_one,
    output logic [NCH-1:0] ch_zero
);
    logic [NCH:0]   below;
    logic [NCH-1:0] pick;

    assign below[0] = 1'b0;

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_tap
            assign below[k+1] = below[k] | sel[k];
            assign pick[k]    = lb_on && sel[k] && !below[k];
            assign ch_one[k]  = pick[k] && one_in;
            assign ch_zero[k] = pick[k] && zero_in;
        end
    endgenerate

    assign ext_one  = !lb_on && one_in;
    assign ext_zero = !lb_on && zero_in;
endmodule

// File: rtl/rz_word_tx.sv
module rz_word_tx #(
    parameter int unsigned NCH      = rzt_pkg::DEF_NCH,
    parameter int unsigned BYTE_W   = rzt_pkg::DEF_BYTE_W,
    parameter int unsigned NBYTES   = rzt_pkg::DEF_NBYTES,
    parameter int unsigned DIV_W    = rzt_pkg::DEF_DIV_W,
    parameter int unsigned GAP_BITS = rzt_pkg::DEF_GAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic              ctrl_prog,
    input  logic              ctrl_start,
    input  logic              ctrl_loop,
    input  logic [NCH-1:0]    ctrl_sel,
    input  logic              byte_we,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [DIV_W-1:0]  div_n,
    output logic              line_one,
    output logic              line_zero,
    output logic              busy,
    output logic              done,
    output logic [NCH-1:0]    lb_one,
    output logic [NCH-1:0]    lb_zero
);
    import rzt_pkg::*;

    localparam int unsigned WORD_W = BYTE_W * NBYTES;
    localparam int unsigned BIT_W  = $clog2(WORD_W);
    localparam int unsigned GAP_W  = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;

    tx_state_e       state_q;
    logic [BIT_W-1:0] bit_q;
    logic [GAP_W-1:0] gap_q;
    logic            pend_q, done_q, lb_q, prog_q;
    logic [NCH-1:0]  sel_q;

    ctrl_word_t cw;
    logic tick, phase_hi, cur_bit;
    logic start_req, launch_idle, last_bit, gap_end, relaunch, restart;
    logic pulse_hi, raw_one, raw_zero;

    assign cw          = '{prog: ctrl_prog, start: ctrl_start, loop: ctrl_loop};
    assign start_req   = ctrl_wr && cw.start;
    assign launch_idle = (state_q == TX_IDLE) && start_req;
    assign last_bit    = (state_q == TX_SHIFT) && tick && (bit_q == BIT_W'(WORD_W-1));
    assign gap_end     = (state_q == TX_GAP) && tick && (gap_q == GAP_W'(GAP_BITS-1));
    assign relaunch    = gap_end && (pend_q || start_req);
    assign restart     = launch_idle || relaunch;

    rzt_bitclk #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (state_q != TX_IDLE),
        .div_raw  (div_n),
        .tick     (tick),
        .phase_hi (phase_hi)
    );

    rzt_shreg #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_word (
        .clk     (clk),
        .rst     (rst),
        .idx_clr (ctrl_wr && cw.prog),
        .byte_wr (byte_we && prog_q && (state_q != TX_SHIFT)),
        .byte_in (byte_data),
        .rotate  ((state_q == TX_SHIFT) && tick),
        .cur_bit (cur_bit)
    );

    assign pulse_hi = (state_q == TX_SHIFT) && phase_hi;
    assign raw_one  = pulse_hi && cur_bit;
    assign raw_zero = pulse_hi && !cur_bit;

    rzt_route #(.NCH(NCH)) u_route (
        .lb_on    (lb_q),
        .sel      (sel_q),
        .one_in   (raw_one),
        .zero_in  (raw_zero),
        .ext_one  (line_one),
        .ext_zero (line_zero),
        .ch_one   (lb_one),
        .ch_zero  (lb_zero)
    );

    // Word sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            bit_q   <= '0;
            gap_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (start_req) begin
                        state_q <= TX_SHIFT;
                        bit_q   <= '0;
                    end
                end
                TX_SHIFT: begin
                    if (last_bit) begin
                        state_q <= TX_GAP;
                        gap_q   <= '0;
                    end else if (tick) begin
                        bit_q <= bit_q + BIT_W'(1);
                    end
                end
                TX_GAP: begin
                    if (gap_end) begin
                        pend_q  <= 1'b0;
                        bit_q   <= '0;
                        state_q <= relaunch ? TX_SHIFT : TX_IDLE;
                    end else begin
                        if (start_req) pend_q <= 1'b1;
                        if (tick)      gap_q  <= gap_q + GAP_W'(1);
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Control and flag registers
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            lb_q   <= 1'b0;
            prog_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                prog_q <= cw.prog;
                sel_q  <= ctrl_sel;
                lb_q   <= cw.loop && cw.start;
            end else if (ctrl_rd) begin
                lb_q <= 1'b0;
            end
            if (ctrl_wr && cw.prog) done_q <= 1'b0;
            if (last_bit)           done_q <= 1'b1;
        end
    end

    assign busy = (state_q == TX_SHIFT);
    assign done = done_q;
endmodule

// File: rtl/rz_word_tx_chk.sv
module rz_word_tx_chk #(
    parameter int unsigned NCH = rzt_pkg::DEF_NCH
) (
    input logic           clk,
    input logic           rst,
    input logic           ctrl_wr,
    input logic           ctrl_rd,
    input logic           ctrl_prog,
    input logic           line_one,
    input logic           line_zero,
    input logic           busy,
    input logic           done,
    input logic [NCH-1:0] lb_one,
    input logic [NCH-1:0] lb_zero
);
    AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(line_one && line_zero)); // R3

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(line_one || line_zero || (|lb_one) || (|lb_zero))); // R7

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R7

    AST_PROG_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_prog && !busy) |=> !done); // R6

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lb_one | lb_zero)); // R10

    AST_TAP_HIDES_LINES: assert property (@(posedge clk) disable iff (rst)
        (|(lb_one | lb_zero)) |-> !(line_one || line_zero)); // R10

    AST_READ_ENDS_LOOP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd && !ctrl_wr) |=> !(|(lb_one | lb_zero))); // R11
endmodule

bind rz_word_tx rz_word_tx_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_rd   (ctrl_rd),
    .ctrl_prog (ctrl_prog),
    .line_one  (line_one),
    .line_zero (line_zero),
    .busy      (busy),
    .done      (done),
    .lb_one    (lb_one),
    .lb_zero   (lb_zero)
);

// File: tb/rz_word_tx_test.sv
module rz_word_tx_test;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_wr = 0, ctrl_rd = 0, ctrl_prog = 0, ctrl_start = 0, ctrl_loop = 0;
    logic [NCH-1:0] ctrl_sel = '0;
    logic byte_we = 0;
    logic [7:0] byte_data = '0;
    logic [7:0] div_n = 8'd2;
    logic line_one, line_zero, busy, done;
    logic [NCH-1:0] lb_one, lb_zero;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    rz_word_tx uut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
        .ctrl_prog(ctrl_prog), .ctrl_start(ctrl_start), .ctrl_loop(ctrl_loop),
        .ctrl_sel(ctrl_sel), .byte_we(byte_we), .byte_data(byte_data),
        .div_n(div_n), .line_one(line_one), .line_zero(line_zero),
        .busy(busy), .done(done), .lb_one(lb_one), .lb_zero(lb_zero)
    );

    typedef struct packed {
        logic [7:0]  div;
        logic [7:0]  ratio;
        logic [31:0] word;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{div: 8'd2, ratio: 8'd2, word: 32'h8000_0001},
        '{div: 8'd6, ratio: 8'd6, word: 32'hA5C3_3C5A},
        '{div: 8'd9, ratio: 8'd8, word: 32'h1234_5678},
        '{div: 8'd1, ratio: 8'd2, word: 32'hFFFF_0000}
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic ctl(input logic p, input logic s, input logic l, input logic [NCH-1:0] sel);
        ctrl_wr = 1; ctrl_prog = p; ctrl_start = s; ctrl_loop = l; ctrl_sel = sel;
        @(posedge clk);
        @(negedge clk);
        ctrl_wr = 0; ctrl_prog = 0; ctrl_start = 0; ctrl_loop = 0;
    endtask

    task automatic wb(input logic [7:0] b);
        byte_we = 1; byte_data = b;
        @(posedge clk);
        @(negedge clk);
        byte_we = 0;
    endtask

    task automatic load_word(input logic [31:0] w);
        ctl(1, 0, 0, '0);
        for (int k = 0; k < 4; k++) wb(w[8*k +: 8]);
    endtask

    // Called at the negedge right after the start edge; returns at the
    // negedge right after the edge that ends the 32nd bit period.
    task automatic capture(input int n, input int ch, output logic [31:0] w, output int bad);
        bad = 0; w = '0;
        for (int k = 0; k < 32; k++) begin
            logic o, z;
            if (ch < 0) begin
                o = line_one; z = line_zero;
                if (|(lb_one | lb_zero)) bad++;
            end else begin
                o = lb_one[ch]; z = lb_zero[ch];
                if (line_one | line_zero) bad++;
            end
            if (o == z) bad++;
            if (busy !== 1'b1) bad++;
            w[k] = o;
            repeat (n / 2) @(negedge clk);
            if (ch < 0) begin
                if (line_one | line_zero) bad++;
            end else begin
                if (lb_one[ch] | lb_zero[ch]) bad++;
            end
            repeat (n - n / 2) @(negedge clk);
        end
    endtask

    task automatic measure(output int cnt);
        cnt = 0;
        ctl(0, 1, 0, '0);
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int bad, cnt;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 lines", {line_one, line_zero, lb_one, lb_zero}, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after release", {busy, done, line_one, line_zero, lb_one, lb_zero}, 0);

        // Vector walk: R2 R3 R4 R5 R7
        for (int v = 0; v < 4; v++) begin
            div_n = VEC[v].div;
            load_word(VEC[v].word);
            ctl(0, 1, 0, '0);
            capture(int'(VEC[v].ratio), -1, w, bad);
            check("R5 word order", w, VEC[v].word);
            check("R2 R3 pulse shape", bad, 0);
            check("R7 busy length", busy, 0);
            check("R7 done set", done, 1);
            check("R7 lines low after", {line_one, line_zero}, 0);
            repeat (4 * int'(VEC[v].ratio) + 2) @(negedge clk);
        end

        // R6: program enable clears done
        ctl(1, 0, 0, '0);
        check("R6 done cleared", done, 0);

        // R4: fifth byte wraps to the label
        div_n = 8'd2;
        wb(8'hA1); wb(8'hB2); wb(8'hC3); wb(8'hD4); wb(8'h5E);
        ctl(0, 1, 0, '0);
        capture(2, -1, w, bad);
        check("R4 index wraps", w, 32'hD4C3_B25E);
        repeat (12) @(negedge clk);

        // R9: start and byte write while busy are ignored
        ctl(1, 1, 0, '0);
        cnt = 0;
        wb(8'hFF); cnt++;
        ctl(0, 1, 0, '0); cnt++;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        check("R9 length unchanged", cnt, 64);
        repeat (4 * 2 + 4) @(negedge clk);
        check("R9 no retransmit", busy, 0);

        // R8: held restart after the gap, same word without reload
        wb(8'h00); // program enable off: ignored (R4)
        ctl(0, 1, 0, '0);
        capture(2, -1, w, bad);
        check("R4 busy and disabled writes ignored", w, 32'hD4C3_B25E);
        ctl(0, 1, 0, '0);
        repeat (4 * 2 - 2) @(negedge clk);
        check("R8 still in gap", {busy, line_one, line_zero}, 0);
        @(negedge clk);
        check("R8 restart on time", busy, 1);
        capture(2, -1, w, bad);
        check("R8 same word resent", w, 32'hD4C3_B25E);
        check("R8 shape", bad, 0);
        repeat (12) @(negedge clk);

        // R2: divider rounding
        div_n = 8'd5;
        measure(cnt);
        check("R2 odd divider rounds down", cnt, 128);
        repeat (20) @(negedge clk);
        div_n = 8'd0;
        measure(cnt);
        check("R2 zero divider uses 2", cnt, 64);
        repeat (12) @(negedge clk);

        // R10: loopback to lowest selected tap
        div_n = 8'd4;
        load_word(32'h0F0F_C0DE);
        ctl(0, 1, 1, 4'b0110);
        capture(4, 1, w, bad);
        check("R10 tap 1 word", w, 32'h0F0F_C0DE);
        check("R10 only tap 1, external quiet", bad, 0);
        repeat (20) @(negedge clk);

        // R11: read strobe ends loopback mid word
        div_n = 8'd8;
        ctl(0, 1, 1, 4'b1000);
        check("R10 tap 3 active", lb_one[3] | lb_zero[3], 1);
        ctrl_rd = 1;
        @(posedge clk);
        @(negedge clk);
        ctrl_rd = 0;
        check("R11 taps released", {lb_one, lb_zero}, 0);
        check("R11 external resumes", line_one | line_zero, 1);
        while (busy) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule